// File: doc/BRIEF.md
# Big-Endian Load/Store Alignment Unit

This unit sits between a 32-bit integer pipeline and a data memory that is one word wide. For each access it forms the effective address. The address is a base register value plus a 16-bit signed displacement. The unit then checks that address against the access size and turns the request into a word-aligned memory address and per-lane byte enables.

Bytes are numbered big-endian inside a word: byte offset 0 is the most significant lane. For stores, the unit copies a byte or half-word onto every lane of matching width, and the byte enables choose the lanes that are written. For loads, the unit keeps the offset, size and extension mode of the accepted request. When the read word comes back, it picks out the addressed field, widens it with sign or zero fill, and registers the result.

A request that breaks the alignment rule for its size sends nothing to memory. Instead it raises a misalignment flag and puts the faulting effective address on a separate output for trap handling.

Top module: `lsu_align`

## Requirements
- R1: `mem_addr` equals `base_val` plus `imm16` sign-extended to 32 bits, with its two low bits forced to zero.
- R2: The size code is 00 byte, 01 half-word, 10 word, and 11 is handled as a word. `misalign` is high when `req_valid` is high and one of these holds: a half-word with effective address bit 0 set, or a word with either of the two low address bits set. Byte accesses never misalign.
- R3: While `misalign` is high, `mem_req`, `mem_we` and `mem_be` are all zero and `fault_addr` carries the full effective address. In every other cycle `fault_addr` is zero.
- R4: `mem_be[i]` enables write-data bits [8i+7:8i], so `mem_be[3]` is byte offset 0. For a store, a byte at offset o enables bit 3-o. A half-word at offset 0 gives 4'b1100, at offset 2 gives 4'b0011, and a word gives 4'b1111. `mem_be` is zero for loads and for idle cycles, and `mem_we` equals `mem_req` and `req_is_store`.
- R5: For stores, `mem_wdata` holds `wr_data[7:0]` copied into all four lanes for a byte, `wr_data[15:0]` copied into both halves for a half-word, and `wr_data` unchanged for a word.
- R6: A loaded byte at offset o is taken from read-data bits [31-8o:24-8o]. A loaded half-word at offset 0 is taken from bits [31:16] and at offset 2 from bits [15:0]. A loaded word is passed through whole.
- R7: Sub-word load results are sign-extended when `ld_signed` was high on the request and zero-extended when it was low.
- R8: `ld_valid` is high exactly in the cycle after a cycle with `mem_rd_valid` high, and `ld_result` updates at that edge and holds at all other times.
- R9: While `rst` is high, and after it, `ld_valid` and `ld_result` are zero until the first read data arrives.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Access strobe from the pipeline |
| req_is_store | input | 1 | 1 for store, 0 for load |
| base_val | input | 32 | Base register value |
| imm16 | input | 16 | Signed address displacement |
| acc_size | input | 2 | Access size code (see R2) |
| ld_signed | input | 1 | Sign-extend sub-word load when high |
| wr_data | input | 32 | Store data, right-justified |
| mem_rd_data | input | 32 | Word read from memory |
| mem_rd_valid | input | 1 | Read word is valid this cycle |
| mem_req | output | 1 | Memory access issued |
| mem_we | output | 1 | Issued access is a write |
| mem_addr | output | 32 | Word-aligned memory address |
| mem_be | output | 4 | Write byte enables |
| mem_wdata | output | 32 | Lane-replicated write data |
| ld_result | output | 32 | Extended load result, registered |
| ld_valid | output | 1 | Load result valid pulse |
| misalign | output | 1 | Alignment exception |
| fault_addr | output | 32 | Faulting effective address |

## Verification
Loads are driven at every byte offset and both half-word offsets. The read words have the sign bit of the selected field set, so a wrong lane choice shows up separately from a wrong fill, and both extension modes are exercised. Stores at each offset check lane choice and copying together. Misaligned half-word and word addresses, including the reserved size code, show that the fault path holds the memory side quiet. Negative displacements that borrow from the base check the address adder, and a random mix of the same shapes is compared against the behavioural model on every access.

// File: rtl/lsu_align_pkg.sv
package lsu_align_pkg;

    parameter int unsigned LSU_XLEN = 32;
    parameter int unsigned LSU_NB   = LSU_XLEN / 8;
    parameter int unsigned LSU_OFFW = $clog2(LSU_NB);

    typedef enum logic [1:0] {
        SZ_BYTE = 2'b00,
        SZ_HALF = 2'b01,
        SZ_WORD = 2'b10,
        SZ_RSVD = 2'b11
    } acc_size_e;

    typedef struct packed {
        logic [LSU_OFFW-1:0] off;
        acc_size_e           size;
        logic                sgn;
    } ld_ctx_t;

    function automatic logic is_misaligned(acc_size_e sz, logic [LSU_OFFW-1:0] lo);
        case (sz)
            SZ_BYTE: return 1'b0;
            SZ_HALF: return lo[0];
            default: return |lo;
        endcase
    endfunction

endpackage

// File: rtl/lsu_ea_gen.sv
module lsu_ea_gen
    import lsu_align_pkg::*;
#(
    parameter int unsigned IMM_W = 16
) (
    input  logic [LSU_XLEN-1:0] base,
    input  logic [IMM_W-1:0]    disp,
    output logic [LSU_XLEN-1:0] ea
);
    localparam int unsigned EXT_W = LSU_XLEN - IMM_W;

    logic [LSU_XLEN-1:0] disp_x;

    assign disp_x = {{EXT_W{disp[IMM_W-1]}}, disp};
    assign ea     = base + disp_x;
endmodule

// File: rtl/lsu_store_lanes.sv
module lsu_store_lanes
    import lsu_align_pkg::*;
(
    input  acc_size_e           size,
    input  logic [LSU_OFFW-1:0] off,
    input  logic                en,
    input  logic [LSU_XLEN-1:0] src,
    output logic [LSU_NB-1:0]   be,
    output logic [LSU_XLEN-1:0] wdata
);
    for (genvar i = 0; i < int'(LSU_NB); i++) begin : g_lane
        localparam logic [LSU_OFFW-1:0] BOFF = LSU_OFFW'(int'(LSU_NB) - 1 - i);
        localparam bit UPPER = (i % 2) == 1;

        logic [7:0] lane_d;
        logic       lane_hit;

        always_comb begin
            case (size)
                SZ_BYTE: begin
                    lane_d   = src[7:0];
                    lane_hit = (off == BOFF);
                end
                SZ_HALF: begin
                    lane_d   = UPPER ? src[15:8] : src[7:0];
                    lane_hit = (off[LSU_OFFW-1:1] == BOFF[LSU_OFFW-1:1]);
                end
                default: begin
                    lane_d   = src[8*i +: 8];
                    lane_hit = 1'b1;
                end
            endcase
        end

        assign wdata[8*i +: 8] = lane_d;
        assign be[i]           = en & lane_hit;
    end
endmodule

// File: rtl/lsu_load_extract.sv
module lsu_load_extract
    import lsu_align_pkg::*;
(
    input  ld_ctx_t             ctx,
    input  logic [LSU_XLEN-1:0] rd,
    output logic [LSU_XLEN-1:0] res
);
    localparam int unsigned SH_W = $clog2(LSU_XLEN);

    logic [SH_W-1:0]     byte_sh;
    logic [SH_W-1:0]     half_sh;
    logic [LSU_XLEN-1:0] byte_w;
    logic [LSU_XLEN-1:0] half_w;
    logic [7:0]          byte_v;
    logic [15:0]         half_v;

    assign byte_sh = SH_W'((int'(LSU_NB) - 1 - int'(ctx.off)) * 8);
    assign half_sh = SH_W'((int'(LSU_NB) - 2 - int'({ctx.off[LSU_OFFW-1:1], 1'b0})) * 8);
    assign byte_w  = rd >> byte_sh;
    assign half_w  = rd >> half_sh;
    assign byte_v  = byte_w[7:0];
    assign half_v  = half_w[15:0];

    always_comb begin
        case (ctx.size)
            SZ_BYTE: res = {{(LSU_XLEN-8){ctx.sgn & byte_v[7]}}, byte_v};
            SZ_HALF: res = {{(LSU_XLEN-16){ctx.sgn & half_v[15]}}, half_v};
            default: res = rd;
        endcase
    end
endmodule

// File: rtl/lsu_align.sv
module lsu_align
    import lsu_align_pkg::*;
#(
    parameter int unsigned IMM_W = 16
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                req_valid,
    input  logic                req_is_store,
    input  logic [31:0]         base_val,
    input  logic [IMM_W-1:0]    imm16,
    input  logic [1:0]          acc_size,
    input  logic                ld_signed,
    input  logic [31:0]         wr_data,
    input  logic [31:0]         mem_rd_data,
    input  logic                mem_rd_valid,
    output logic                mem_req,
    output logic                mem_we,
    output logic [31:0]         mem_addr,
    output logic [3:0]          mem_be,
    output logic [31:0]         mem_wdata,
    output logic [31:0]         ld_result,
    output logic                ld_valid,
    output logic                misalign,
    output logic [31:0]         fault_addr
);
    logic [LSU_XLEN-1:0] ea;
    logic [LSU_OFFW-1:0] ea_lo;
    acc_size_e           sz;
    logic                bad;
    logic                st_go;
    ld_ctx_t             ctx_q;
    logic [LSU_XLEN-1:0] ext_val;

    assign sz = acc_size_e'(acc_size);

    lsu_ea_gen #(.IMM_W(IMM_W)) u_ea (
        .base (base_val),
        .disp (imm16),
        .ea   (ea)
    );

    assign ea_lo      = ea[LSU_OFFW-1:0];
    assign bad        = is_misaligned(sz, ea_lo);
    assign misalign   = req_valid & bad;
    assign mem_req    = req_valid & ~bad;
    assign mem_we     = mem_req & req_is_store;
    assign st_go      = mem_we;
    assign mem_addr   = {ea[LSU_XLEN-1:LSU_OFFW], {LSU_OFFW{1'b0}}};
    assign fault_addr = misalign ? ea : '0;

    lsu_store_lanes u_st (
        .size  (sz),
        .off   (ea_lo),
        .en    (st_go),
        .src   (wr_data),
        .be    (mem_be),
        .wdata (mem_wdata)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            ctx_q <= '{off: '0, size: SZ_WORD, sgn: 1'b0};
        end else if (mem_req && !req_is_store) begin
            ctx_q <= '{off: ea_lo, size: sz, sgn: ld_signed};
        end
    end

    lsu_load_extract u_ld (
        .ctx (ctx_q),
        .rd  (mem_rd_data),
        .res (ext_val)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            ld_valid  <= 1'b0;
            ld_result <= '0;
        end else begin
            ld_valid <= mem_rd_valid;
            if (mem_rd_valid) begin
                ld_result <= ext_val;
            end
        end
    end
endmodule

// File: rtl/lsu_align_chk.sv
module lsu_align_chk (
    input logic        clk,
    input logic        rst,
    input logic        req_valid,
    input logic        mem_rd_valid,
    input logic        mem_req,
    input logic        mem_we,
    input logic [31:0] mem_addr,
    input logic [3:0]  mem_be,
    input logic [31:0] ld_result,
    input logic        ld_valid,
    input logic        misalign,
    input logic [31:0] fault_addr
);
    // R1
    addr_word_aligned_chk: assert property (@(posedge clk) disable iff (rst)
        mem_addr[1:0] == 2'b00);

    // R2
    misalign_needs_req_chk: assert property (@(posedge clk) disable iff (rst)
        misalign |-> req_valid && fault_addr[1:0] != 2'b00);

    // R3
    misalign_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        misalign |-> !mem_req && !mem_we && mem_be == 4'b0000);

    // R3
    fault_idle_zero_chk: assert property (@(posedge clk) disable iff (rst)
        !misalign |-> fault_addr == 32'h0);

    // R4
    be_shape_chk: assert property (@(posedge clk) disable iff (rst)
        mem_we |-> (mem_be == 4'b1111 || mem_be == 4'b1100 || mem_be == 4'b0011
                    || $countones(mem_be) == 1));

    // R4
    be_idle_chk: assert property (@(posedge clk) disable iff (rst)
        !mem_we |-> mem_be == 4'b0000);

    // R8
    ld_follow_chk: assert property (@(posedge clk) disable iff (rst)
        mem_rd_valid |=> ld_valid);

    // R8
    ld_no_spurious_chk: assert property (@(posedge clk) disable iff (rst)
        !mem_rd_valid |=> !ld_valid && $stable(ld_result));
endmodule

bind lsu_align lsu_align_chk u_chk (
    .clk          (clk),
    .rst          (rst),
    .req_valid    (req_valid),
    .mem_rd_valid (mem_rd_valid),
    .mem_req      (mem_req),
    .mem_we       (mem_we),
    .mem_addr     (mem_addr),
    .mem_be       (mem_be),
    .ld_result    (ld_result),
    .ld_valid     (ld_valid),
    .misalign     (misalign),
    .fault_addr   (fault_addr)
);

// File: tb/lsu_align_bench.sv
module lsu_align_bench;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst;
    logic        req_valid, req_is_store, ld_signed, mem_rd_valid;
    logic [31:0] base_val, wr_data, mem_rd_data;
    logic [15:0] imm16;
    logic [1:0]  acc_size;
    logic        mem_req, mem_we, ld_valid, misalign;
    logic [31:0] mem_addr, mem_wdata, ld_result, fault_addr;
    logic [3:0]  mem_be;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    lsu_align u_lsu_align (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_is_store(req_is_store),
        .base_val(base_val), .imm16(imm16), .acc_size(acc_size), .ld_signed(ld_signed),
        .wr_data(wr_data), .mem_rd_data(mem_rd_data), .mem_rd_valid(mem_rd_valid),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_be(mem_be),
        .mem_wdata(mem_wdata), .ld_result(ld_result), .ld_valid(ld_valid),
        .misalign(misalign), .fault_addr(fault_addr)
    );

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s act=%h exp=%h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic access(bit st, logic [31:0] b, logic [15:0] d, logic [1:0] sz,
                          bit sg, logic [31:0] wd, logic [31:0] rdw);
        logic [31:0] ea, exp_ld, exp_wd;
        logic [3:0]  exp_be;
        int          off;
        bit          bad;
        @(negedge clk);
        req_valid = 1; req_is_store = st; base_val = b; imm16 = d;
        acc_size = sz; ld_signed = sg; wr_data = wd; mem_rd_valid = 0;
        #1;
        ea  = b + {{16{d[15]}}, d};
        off = int'(ea[1:0]);
        bad = (sz == 2'b01) ? (off % 2 != 0) : (sz == 2'b00) ? 1'b0 : (off != 0);
        check("R1 mem_addr", mem_addr, {ea[31:2], 2'b00});
        check("R2 misalign", {31'd0, misalign}, {31'd0, bad});
        check("R3 fault_addr", fault_addr, bad ? ea : 32'h0);
        check("R3 mem_req", {31'd0, mem_req}, {31'd0, !bad});
        exp_be = 4'b0000;
        if (st && !bad) begin
            if (sz == 2'b00)      exp_be = 4'b0001 << (3 - off);
            else if (sz == 2'b01) exp_be = (off == 0) ? 4'b1100 : 4'b0011;
            else                  exp_be = 4'b1111;
        end
        check("R4 mem_be", {28'd0, mem_be}, {28'd0, exp_be});
        check("R4 mem_we", {31'd0, mem_we}, {31'd0, st && !bad});
        if (st && !bad) begin
            if (sz == 2'b00)      exp_wd = {4{wd[7:0]}};
            else if (sz == 2'b01) exp_wd = {2{wd[15:0]}};
            else                  exp_wd = wd;
            check("R5 mem_wdata", mem_wdata, exp_wd);
        end
        @(negedge clk);
        req_valid = 0;
        if (!st && !bad) begin
            mem_rd_valid = 1; mem_rd_data = rdw;
            if (sz == 2'b00) begin
                exp_ld = (rdw >> (8 * (3 - off))) & 32'hFF;
                if (sg && exp_ld[7]) exp_ld |= 32'hFFFF_FF00;
            end else if (sz == 2'b01) begin
                exp_ld = (rdw >> (8 * (2 - off))) & 32'hFFFF;
                if (sg && exp_ld[15]) exp_ld |= 32'hFFFF_0000;
            end else begin
                exp_ld = rdw;
            end
            @(negedge clk);
            mem_rd_valid = 0;
            check("R8 ld_valid pulse", {31'd0, ld_valid}, 32'd1);
            check(sz == 2'b10 || sz == 2'b11 ? "R6 ld_result" : "R7 ld_result", ld_result, exp_ld);
            @(negedge clk);
            check("R8 ld_valid drop", {31'd0, ld_valid}, 32'd0);
            check("R8 ld_result hold", ld_result, exp_ld);
        end else begin
            check("R3 no load issued", {31'd0, ld_valid}, 32'd0);
        end
    endtask

    initial begin
        rst = 1; req_valid = 0; req_is_store = 0; base_val = 0; imm16 = 0;
        acc_size = 0; ld_signed = 0; wr_data = 0; mem_rd_data = 0; mem_rd_valid = 0;
        repeat (3) @(negedge clk);
        check("R9 reset ld_valid", {31'd0, ld_valid}, 32'd0);
        check("R9 reset ld_result", ld_result, 32'd0);
        rst = 0;
        @(negedge clk);
        check("R9 idle ld_valid", {31'd0, ld_valid}, 32'd0);
        // R6 R7: every byte lane, both fills
        for (int o = 0; o < 4; o++) begin
            access(0, 32'h0000_1000, 16'(o), 2'b00, 1, 32'h0, 32'h8A9B_ACBD);
            access(0, 32'h0000_1000, 16'(o), 2'b00, 0, 32'h0, 32'h8A9B_ACBD);
        end
        for (int o = 0; o < 4; o += 2) begin
            access(0, 32'h0000_2000, 16'(o), 2'b01, 1, 32'h0, 32'h8123_F456);
            access(0, 32'h0000_2000, 16'(o), 2'b01, 0, 32'h0, 32'h8123_F456);
        end
        access(0, 32'h0000_3000, 16'h0004, 2'b10, 1, 32'h0, 32'hDEAD_BEEF);
        // R5 R4: stores at each offset
        for (int o = 0; o < 4; o++) access(1, 32'h0000_4000, 16'(o), 2'b00, 0, 32'h1122_33C4, 32'h0);
        access(1, 32'h0000_4000, 16'h0000, 2'b01, 0, 32'hAAAA_5678, 32'h0);
        access(1, 32'h0000_4000, 16'h0002, 2'b01, 0, 32'hAAAA_5678, 32'h0);
        access(1, 32'h0000_4000, 16'h0008, 2'b10, 0, 32'hCAFE_F00D, 32'h0);
        // R2 R3: misaligned
        access(0, 32'h0000_5000, 16'h0001, 2'b01, 1, 32'h0, 32'h0);
        access(1, 32'h0000_5000, 16'h0003, 2'b01, 0, 32'h1234, 32'h0);
        for (int o = 1; o < 4; o++) access(1, 32'h0000_5000, 16'(o), 2'b10, 0, 32'h5, 32'h0);
        access(0, 32'h0000_5002, 16'h0000, 2'b11, 0, 32'h0, 32'h0);
        // R1: negative displacement borrow
        access(0, 32'h0001_0000, 16'hFFFC, 2'b10, 0, 32'h0, 32'h0BAD_F00D);
        access(1, 32'h0000_0003, 16'hFFFE, 2'b00, 0, 32'h77, 32'h0);
        for (int n = 0; n < 60; n++)
            access(1'($urandom), $urandom, 16'($urandom), 2'($urandom), 1'($urandom),
                   $urandom, $urandom);
        done = 1;
        $display("test done: total=%0d bad=%0d", checks, fails);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", checks, fails);
            $finish;
        end
    end
endmodule